// File: doc/BRIEF.md
# Serial EEPROM Slave Command Engine

This block is the device-side front end of a small serial memory. A host drives three wires: an active-low chip select, a serial clock and a data input. The block samples all three with a faster system clock. It decodes 32-bit instruction frames and answers on a data output pin. That pin has a separate enable, so a pad cell can model high impedance. Behind the block sit a 128-word by 16-bit array with a combinational read port and a programming controller. The controller owns the write timing and the write-protect state, and it reports when it is busy.

A frame is an 8-bit opcode, an 8-bit address field and 16 data bits, each sent most significant bit first. A read stops taking input after the address field. It then streams words out for as long as the host keeps clocking, and the address wraps at the top of the array. Write, write-enable and write-disable frames are collected in full and passed to the programming controller as a one-cycle request. The serial clock level at the moment chip select is asserted picks the mode. A high clock starts a command. A low clock enters a status mode, in which the output pin shows whether the controller is ready.

Top module: `eep_cmd_engine`

## Requirements
- R1: While reset is asserted, and afterwards until a frame calls for it, `do_oe_o` and `prog_req_o` are 0.
- R2: When `cs_n_i` falls while `sk_i` is high, the block enters command mode and `do_oe_o` stays 0. DI is sampled on rising SK edges, and DO changes only on falling SK edges. Every pin effect appears two system clocks after the pins are sampled.
- R3: When `cs_n_i` falls while `sk_i` is low, the block enters status mode. `do_oe_o`=1 and `do_o` = NOT `busy_i` (1 ready, 0 busy). This holds while DI is clocked in as 0. It ends when `cs_n_i` rises, or when a 1 is clocked in. That 1 counts as the first opcode bit of a frame.
- R4: Opcode 10101000 is a read. The address field carries the word address in its upper 7 bits, and its lowest bit is 0. DO becomes enabled at the 17th falling SK edge and shifts out the addressed word, bit 15 first.
- R5: While SK keeps toggling after a read word, the next word follows with no gap. The address increments by one and wraps from 0x7F to 0x00.
- R6: Opcodes 10100100 (write), 10100011 (write enable) and 10100000 (write disable) produce a single-cycle `prog_req_o` after the 32nd rising SK edge. `prog_cmd_o` is 01, 10 or 11 respectively. `prog_addr_o` is the upper 7 bits of the address field and `prog_wdata_o` is the 16 data bits. For the enable and disable opcodes, the address and data bits are ignored.
- R7: A rise of `cs_n_i` at any point aborts the frame. DO is disabled and no request is issued.
- R8: Any other opcode, 10101111 included, is ignored until `cs_n_i` rises. No request is issued and DO stays disabled.
- R9: A command frame that begins while `busy_i` is 1 is ignored in full: no request and no read data. A status-mode entry still answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select from host, active low, asynchronous |
| sk_i | input | 1 | Serial clock from host, asynchronous |
| di_i | input | 1 | Serial data from host, asynchronous |
| busy_i | input | 1 | Programming controller is in a write cycle |
| mem_rdata_i | input | 16 | Array word at `mem_addr_o`, combinational |
| do_o | output | 1 | Serial data or status toward host |
| do_oe_o | output | 1 | Output enable for `do_o`; 0 means high impedance |
| mem_addr_o | output | 7 | Array read address |
| prog_req_o | output | 1 | One-cycle request to the programming controller |
| prog_cmd_o | output | 2 | Request kind: 01 write, 10 enable, 11 disable |
| prog_addr_o | output | 7 | Word address for a write request |
| prog_wdata_o | output | 16 | Data word for a write request |

## Verification
The assertions assume that the host never moves chip select and the serial clock in the same system clock. They also assume that each SK half-period is longer than the two-flop synchronizer delay, so each sampled edge is a clean, isolated event. The stimulus holds every SK level for six system clocks. It changes chip select only while SK rests at a steady level. It changes `busy_i` only between frames or inside status mode, so the ready/busy check and the busy-frame check see one stable value over a frame.

// File: rtl/eep_cmd_pkg.sv
package eep_cmd_pkg;

  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OPC_READ  = 8'b1010_1000;
  localparam logic [OP_W-1:0] OPC_WRITE = 8'b1010_0100;
  localparam logic [OP_W-1:0] OPC_WREN  = 8'b1010_0011;
  localparam logic [OP_W-1:0] OPC_WRDS  = 8'b1010_0000;

  typedef enum logic [1:0] {
    PCMD_NONE  = 2'b00,
    PCMD_WRITE = 2'b01,
    PCMD_WREN  = 2'b10,
    PCMD_WRDS  = 2'b11
  } pcmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STAT,
    ST_RX,
    ST_READ,
    ST_HOLD
  } eng_st_e;

  function automatic pcmd_e prog_decode(input logic [OP_W-1:0] op);
    pcmd_e r;
    case (op)
      OPC_WRITE: r = PCMD_WRITE;
      OPC_WREN:  r = PCMD_WREN;
      OPC_WRDS:  r = PCMD_WRDS;
      default:   r = PCMD_NONE;
    endcase
    return r;
  endfunction

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return (op == OPC_READ) || (prog_decode(op) != PCMD_NONE);
  endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int               WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= {2{RST_VAL[g]}};
      end else begin
        stg_q <= {stg_q[0], d_i[g]};
      end
    end

    assign q_o[g] = stg_q[1];
  end

endmodule

// File: rtl/eep_edge.sv
module eep_edge #(
  parameter int               WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= RST_VAL;
    end else begin
      prev_q <= d_i;
    end
  end

  assign rise_o = d_i & ~prev_q;
  assign fall_o = ~d_i & prev_q;

endmodule

// File: rtl/eep_read_ptr.sv
module eep_read_ptr #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bit_o
);

  localparam int BCNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BCNT_W-1:0] BIT_LAST = BCNT_W'(DATA_W - 1);

  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [BCNT_W-1:0] bcnt_q, bcnt_n;
  logic              upd_en;

  always_comb begin
    addr_n = addr_q;
    bcnt_n = bcnt_q;
    upd_en = 1'b0;
    if (load_i) begin
      upd_en = 1'b1;
      addr_n = load_addr_i;
      bcnt_n = '0;
    end else if (step_i) begin
      upd_en = 1'b1;
      if (bcnt_q == BIT_LAST) begin
        bcnt_n = '0;
        addr_n = addr_q + ADDR_W'(1);
      end else begin
        bcnt_n = bcnt_q + BCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bcnt_q <= '0;
    end else if (upd_en) begin
      addr_q <= addr_n;
      bcnt_q <= bcnt_n;
    end
  end

  assign addr_o = addr_q;
  assign bit_o  = rdata_i[BIT_LAST - bcnt_q];

endmodule

// File: rtl/eep_cmd_engine.sv
module eep_cmd_engine
  import eep_cmd_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int AF_W   = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sk_i,
  input  logic              di_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              do_o,
  output logic              do_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              prog_req_o,
  output logic [1:0]        prog_cmd_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_wdata_o
);

  localparam int FRAME_W = OP_W + AF_W + DATA_W;
  localparam int SR_W    = FRAME_W - 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_OP    = CNT_W'(OP_W);
  localparam logic [CNT_W-1:0] CNT_HDR   = CNT_W'(OP_W + AF_W);
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_W);

  // synchronized pins and edges
  logic [2:0] sync_bus;
  logic       cs_s, sk_s, di_s;
  logic       cs_rise, sk_rise, cs_fall, sk_fall;

  eep_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cs_n_i, sk_i, di_i}),
    .q_o   (sync_bus)
  );

  assign {cs_s, sk_s, di_s} = sync_bus;

  eep_edge #(.WIDTH(2), .RST_VAL(2'b10)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    ({cs_s, sk_s}),
    .rise_o ({cs_rise, sk_rise}),
    .fall_o ({cs_fall, sk_fall})
  );

  // read address and bit pointer
  logic              rd_load, rd_step, rd_bit;
  logic [ADDR_W-1:0] rd_load_addr;

  eep_read_ptr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (rd_load),
    .load_addr_i (rd_load_addr),
    .step_i      (rd_step),
    .rdata_i     (mem_rdata_i),
    .addr_o      (mem_addr_o),
    .bit_o       (rd_bit)
  );

  // engine state
  eng_st_e           st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_inc;
  logic [SR_W-1:0]   sr_q, sr_n;
  logic [FRAME_W-1:0] frame_w;
  logic              oe_q, oe_n;
  logic              do_q, do_n;
  logic              req_q, req_n;
  pcmd_e             cmd_q, cmd_n;
  logic [ADDR_W-1:0] paddr_q, paddr_n;
  logic [DATA_W-1:0] pdata_q, pdata_n;

  assign frame_w      = {sr_q, di_s};
  assign cnt_inc      = cnt_q + CNT_W'(1);
  assign rd_load_addr = frame_w[AF_W-1 -: ADDR_W];

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    sr_n    = sr_q;
    oe_n    = oe_q;
    do_n    = do_q;
    req_n   = 1'b0;
    cmd_n   = cmd_q;
    paddr_n = paddr_q;
    pdata_n = pdata_q;
    rd_load = 1'b0;
    rd_step = 1'b0;

    if (cs_rise) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
      do_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (cs_fall) begin
            if (!sk_s) begin
              st_n = ST_STAT;
              oe_n = 1'b1;
              do_n = !busy_i;
            end else if (busy_i) begin
              st_n = ST_HOLD;
            end else begin
              st_n  = ST_RX;
              cnt_n = '0;
            end
          end
        end
        ST_STAT: begin
          do_n = !busy_i;
          if (sk_rise && di_s) begin
            oe_n = 1'b0;
            do_n = 1'b0;
            if (busy_i) begin
              st_n = ST_HOLD;
            end else begin
              st_n  = ST_RX;
              cnt_n = CNT_W'(1);
              sr_n  = SR_W'(1);
            end
          end
        end
        ST_RX: begin
          if (sk_rise) begin
            sr_n  = frame_w[SR_W-1:0];
            cnt_n = cnt_inc;
            if ((cnt_inc == CNT_OP) && !op_known(frame_w[OP_W-1:0])) begin
              st_n = ST_HOLD;
            end else if ((cnt_inc == CNT_HDR) &&
                         (frame_w[AF_W+OP_W-1 -: OP_W] == OPC_READ)) begin
              st_n    = ST_READ;
              rd_load = 1'b1;
            end else if (cnt_inc == CNT_FRAME) begin
              st_n    = ST_HOLD;
              req_n   = 1'b1;
              cmd_n   = prog_decode(frame_w[FRAME_W-1 -: OP_W]);
              paddr_n = frame_w[DATA_W+AF_W-1 -: ADDR_W];
              pdata_n = frame_w[DATA_W-1:0];
            end
          end
        end
        ST_READ: begin
          if (sk_fall) begin
            rd_step = 1'b1;
            oe_n    = 1'b1;
            do_n    = rd_bit;
          end
        end
        ST_HOLD: begin
          oe_n = 1'b0;
        end
        default: begin
          st_n = ST_IDLE;
          oe_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sr_q  <= '0;
      oe_q  <= 1'b0;
      do_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sr_q  <= sr_n;
      oe_q  <= oe_n;
      do_q  <= do_n;
      req_q <= req_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= PCMD_NONE;
      paddr_q <= '0;
      pdata_q <= '0;
    end else if (req_n) begin
      cmd_q   <= cmd_n;
      paddr_q <= paddr_n;
      pdata_q <= pdata_n;
    end
  end

  assign do_o         = do_q;
  assign do_oe_o      = oe_q;
  assign prog_req_o   = req_q;
  assign prog_cmd_o   = cmd_q;
  assign prog_addr_o  = paddr_q;
  assign prog_wdata_o = pdata_q;

endmodule

// File: rtl/eep_cmd_engine_chk.sv
module eep_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_i,
  input logic       do_o,
  input logic       do_oe_o,
  input logic       prog_req_o,
  input logic [1:0] prog_cmd_o,
  input logic       cs_s,
  input logic       cs_fall,
  input logic       sk_s,
  input logic       sk_fall,
  input logic       in_read,
  input logic       in_stat
);

  logic busy_frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_frame_q <= 1'b0;
    end else if (cs_s) begin
      busy_frame_q <= 1'b0;
    end else if (cs_fall && sk_s && busy_i) begin
      busy_frame_q <= 1'b1;
    end
  end

  // R7
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s) |=> !do_oe_o);

  // R6
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req_o |=> !prog_req_o);

  // R6
  req_kind_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req_o |-> (prog_cmd_o != 2'b00));

  // R9
  busy_frame_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req_o |-> !busy_frame_q);

  // R2
  read_on_sk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_read) && do_oe_o && $past(do_oe_o) && (do_o != $past(do_o)))
      |-> $past(sk_fall));

  // R3
  status_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_stat) && in_stat) |-> (do_oe_o && (do_o == !$past(busy_i))));

endmodule

bind eep_cmd_engine eep_cmd_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_i     (busy_i),
  .do_o       (do_o),
  .do_oe_o    (do_oe_o),
  .prog_req_o (prog_req_o),
  .prog_cmd_o (prog_cmd_o),
  .cs_s       (cs_s),
  .cs_fall    (cs_fall),
  .sk_s       (sk_s),
  .sk_fall    (sk_fall),
  .in_read    (st_q == eep_cmd_pkg::ST_READ),
  .in_stat    (st_q == eep_cmd_pkg::ST_STAT)
);

// File: tb/eep_cmd_engine_tb.sv
module eep_cmd_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, sk, di, busy;
  logic [15:0] mem_rdata;
  logic        do_o, do_oe_o, prog_req_o;
  logic [6:0]  mem_addr, prog_addr;
  logic [1:0]  prog_cmd;
  logic [15:0] prog_wdata;

  logic [15:0] mem [128];

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr];

  eep_cmd_engine u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n_i       (cs_n),
    .sk_i         (sk),
    .di_i         (di),
    .busy_i       (busy),
    .mem_rdata_i  (mem_rdata),
    .do_o         (do_o),
    .do_oe_o      (do_oe_o),
    .mem_addr_o   (mem_addr),
    .prog_req_o   (prog_req_o),
    .prog_cmd_o   (prog_cmd),
    .prog_addr_o  (prog_addr),
    .prog_wdata_o (prog_wdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // request capture
  int          req_cnt = 0;
  logic [1:0]  cap_cmd;
  logic [6:0]  cap_addr;
  logic [15:0] cap_data;

  always @(posedge clk) begin
    if (rst_n && prog_req_o) begin
      req_cnt  <= req_cnt + 1;
      cap_cmd  <= prog_cmd;
      cap_addr <= prog_addr;
      cap_data <= prog_wdata;
    end
  end

  // behavioural reference model, pins seen through a two-edge delay
  logic [2:0]  hp [4];
  int          ms;
  int          m_cnt, m_bit;
  logic [31:0] m_frame;
  logic [6:0]  m_addr, m_paddr;
  logic [15:0] m_pdata;
  logic [1:0]  m_cmd;
  logic        m_oe, m_do, m_req;

  function automatic logic [1:0] kind_of(logic [7:0] op);
    if (op == 8'hA4) return 2'b01;
    if (op == 8'hA3) return 2'b10;
    if (op == 8'hA0) return 2'b11;
    return 2'b00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic c, s, d, pc, ps;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) hp[i] = 3'b100;
      ms = 0; m_cnt = 0; m_bit = 15; m_frame = '0; m_addr = '0;
      m_oe = 1'b0; m_do = 1'b0; m_req = 1'b0;
      m_cmd = 2'b00; m_paddr = '0; m_pdata = '0;
    end else begin
      hp[0] = hp[1]; hp[1] = hp[2]; hp[2] = hp[3]; hp[3] = {cs_n, sk, di};
      c = hp[1][2]; s = hp[1][1]; d = hp[1][0]; pc = hp[0][2]; ps = hp[0][1];
      m_req = 1'b0;
      if (c && !pc) begin
        ms = 0; m_oe = 1'b0; m_do = 1'b0;
      end else begin
        case (ms)
          0: if (!c && pc) begin
               if (!s) begin ms = 1; m_oe = 1'b1; m_do = !busy; end
               else if (busy) ms = 4;
               else begin ms = 2; m_cnt = 0; end
             end
          1: begin
               m_do = !busy;
               if (s && !ps && d) begin
                 m_oe = 1'b0; m_do = 1'b0;
                 if (busy) ms = 4;
                 else begin ms = 2; m_cnt = 1; m_frame = 32'd1; end
               end
             end
          2: if (s && !ps) begin
               m_frame = {m_frame[30:0], d};
               m_cnt++;
               if (m_cnt == 8 && m_frame[7:0] != 8'hA8 && kind_of(m_frame[7:0]) == 2'b00)
                 ms = 4;
               else if (m_cnt == 16 && m_frame[15:8] == 8'hA8) begin
                 ms = 3; m_addr = m_frame[7:1]; m_bit = 15;
               end else if (m_cnt == 32) begin
                 ms = 4; m_req = 1'b1; m_cmd = kind_of(m_frame[31:24]);
                 m_paddr = m_frame[23:17]; m_pdata = m_frame[15:0];
               end
             end
          3: if (!s && ps) begin
               m_do = mem[m_addr][m_bit];
               m_oe = 1'b1;
               if (m_bit == 0) begin m_bit = 15; m_addr = m_addr + 7'd1; end
               else m_bit--;
             end
          default: m_oe = 1'b0;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R3 R4 model do_oe", {31'd0, do_oe_o}, {31'd0, m_oe});
      if (m_oe) chk("R4 R5 model do", {31'd0, do_o}, {31'd0, m_do});
      chk("R6 model req", {31'd0, prog_req_o}, {31'd0, m_req});
      if (m_req) begin
        chk("R6 model cmd", {30'd0, prog_cmd}, {30'd0, m_cmd});
        chk("R6 model addr", {25'd0, prog_addr}, {25'd0, m_paddr});
        chk("R6 model data", {16'd0, prog_wdata}, {16'd0, m_pdata});
      end
    end
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_cmd();
    sk = 1'b1; hold(HALF);
    cs_n = 1'b0; hold(HALF);
  endtask

  task automatic desel();
    sk = 1'b1; hold(HALF);
    cs_n = 1'b1; hold(HALF*2);
  endtask

  task automatic tx_bit(logic b);
    sk = 1'b0; di = b; hold(HALF);
    sk = 1'b1; hold(HALF);
  endtask

  task automatic tx_bits(logic [31:0] v, int n);
    for (int i = n-1; i >= 0; i--) tx_bit(v[i]);
  endtask

  task automatic rx_bit(output logic b, output logic en);
    sk = 1'b0; hold(HALF);
    b = do_o; en = do_oe_o;
    sk = 1'b1; hold(HALF);
  endtask

  task automatic rx_word(output logic [15:0] w, output logic all_en);
    logic b, en;
    all_en = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      rx_bit(b, en);
      w[i] = b;
      all_en = all_en & en;
    end
  endtask

  task automatic read_burst(logic [6:0] a0, int n);
    logic [15:0] w;
    logic        en;
    logic [6:0]  a;
    a = a0;
    sel_cmd();
    tx_bits({16'd0, 8'hA8, a0, 1'b0}, 16);
    for (int k = 0; k < n; k++) begin
      rx_word(w, en);
      if (k == 0) begin
        chk("R4 first word data", {16'd0, w}, {16'd0, mem[a]});
        chk("R4 DO enabled from 17th fall", {31'd0, en}, 32'd1);
      end else begin
        chk("R5 streamed word data", {16'd0, w}, {16'd0, mem[a]});
        chk("R5 DO held enabled", {31'd0, en}, 32'd1);
      end
      a = a + 7'd1;
    end
    desel();
    chk("R7 DO released after deselect", {31'd0, do_oe_o}, 32'd0);
  endtask

  task automatic frame32(logic [7:0] op, logic [6:0] a, logic [15:0] d);
    sel_cmd();
    tx_bits({op, a, 1'b0, d}, 32);
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int   base;
    logic b, en;
    logic [15:0] w;
    for (int i = 0; i < 128; i++) mem[i] = 16'(i * 16'h1357) ^ 16'hA5A5;
    cs_n = 1'b1; sk = 1'b0; di = 1'b0; busy = 1'b0; rst_n = 1'b0;
    hold(5);
    chk("R1 DO disabled in reset", {31'd0, do_oe_o}, 32'd0);
    chk("R1 no request in reset", {31'd0, prog_req_o}, 32'd0);
    rst_n = 1'b1;
    hold(5);
    chk("R1 DO disabled after reset", {31'd0, do_oe_o}, 32'd0);

    // R2: command mode entry keeps DO off
    sel_cmd();
    chk("R2 command mode DO off", {31'd0, do_oe_o}, 32'd0);
    desel();

    // R4 R5 reads, including wrap
    read_burst(7'h05, 3);
    read_burst(7'h7E, 3);
    read_burst(7'h00, 1);

    // R6 requests
    base = req_cnt;
    frame32(8'hA4, 7'h12, 16'hBEEF);
    chk("R6 write count", req_cnt, base + 1);
    chk("R6 write cmd", {30'd0, cap_cmd}, 32'd1);
    chk("R6 write addr", {25'd0, cap_addr}, 32'h12);
    chk("R6 write data", {16'd0, cap_data}, 32'hBEEF);
    frame32(8'hA3, 7'h55, 16'h1234);
    chk("R6 enable count", req_cnt, base + 2);
    chk("R6 enable cmd", {30'd0, cap_cmd}, 32'd2);
    frame32(8'hA0, 7'h7F, 16'hFFFF);
    chk("R6 disable count", req_cnt, base + 3);
    chk("R6 disable cmd", {30'd0, cap_cmd}, 32'd3);

    // R8 undefined opcodes
    base = req_cnt;
    sel_cmd();
    tx_bits({8'hAF, 7'h11, 1'b0, 16'hCAFE}, 32);
    chk("R8 test opcode DO off", {31'd0, do_oe_o}, 32'd0);
    rx_bit(b, en);
    chk("R8 test opcode no output", {31'd0, en}, 32'd0);
    desel();
    frame32(8'h00, 7'h22, 16'h0F0F);
    chk("R8 no request", req_cnt, base);

    // R7 abort
    base = req_cnt;
    sel_cmd();
    tx_bits({16'd0, 8'hA4, 7'h33, 1'b0}, 16);
    tx_bits(32'hF, 4);
    desel();
    chk("R7 aborted write no request", req_cnt, base);
    sel_cmd();
    tx_bits({16'd0, 8'hA8, 7'h40, 1'b0}, 16);
    for (int i = 0; i < 5; i++) rx_bit(b, en);
    chk("R7 read driving before abort", {31'd0, en}, 32'd1);
    desel();
    chk("R7 read aborted DO off", {31'd0, do_oe_o}, 32'd0);

    // R3 status mode
    busy = 1'b1;
    sk = 1'b0; hold(HALF);
    cs_n = 1'b0; hold(HALF);
    chk("R3 status enabled", {31'd0, do_oe_o}, 32'd1);
    chk("R3 status busy level", {31'd0, do_o}, 32'd0);
    busy = 1'b0; hold(4);
    chk("R3 status ready level", {31'd0, do_o}, 32'd1);
    sk = 1'b0; hold(HALF);
    cs_n = 1'b1; hold(HALF);
    chk("R3 status ends on deselect", {31'd0, do_oe_o}, 32'd0);

    base = req_cnt;
    sk = 1'b0; hold(HALF);
    cs_n = 1'b0; hold(HALF);
    tx_bit(1'b0); tx_bit(1'b0);
    chk("R3 zeros keep status", {31'd0, do_oe_o}, 32'd1);
    tx_bit(1'b1);
    chk("R3 first one ends status", {31'd0, do_oe_o}, 32'd0);
    tx_bits(32'h23, 7);
    tx_bits(32'h0, 24);
    desel();
    chk("R3 frame after status count", req_cnt, base + 1);
    chk("R3 frame after status cmd", {30'd0, cap_cmd}, 32'd2);

    // R9 busy ignores command frames
    busy = 1'b1;
    base = req_cnt;
    frame32(8'hA4, 7'h44, 16'h1234);
    chk("R9 busy write ignored", req_cnt, base);
    sel_cmd();
    tx_bits({16'd0, 8'hA8, 7'h10, 1'b0}, 16);
    rx_word(w, en);
    chk("R9 busy read no output", {31'd0, en}, 32'd0);
    desel();
    sk = 1'b0; hold(HALF);
    cs_n = 1'b0; hold(HALF);
    chk("R9 status still answers", {31'd0, do_oe_o}, 32'd1);
    chk("R9 status shows busy", {31'd0, do_o}, 32'd0);
    sk = 1'b0; hold(HALF);
    cs_n = 1'b1; hold(HALF);
    busy = 1'b0;
    hold(4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule